// File: doc/BRIEF.md
# Byte/Word Arithmetic Unit with Status Register

This block performs one of seven data operations on a pair of 8-bit or 16-bit operands and keeps a 16-bit processor status word. The status word holds six condition bits and three control bits. The operations are move, exchange, add, subtract, increment, decrement and negate. Operand A is the destination operand and operand B is the source operand. The result appears combinationally on the result port. The status word is updated on the clock edge that follows a strobed operation. The condition bits that an operation touches depend on its class: some classes update all six, some update all but carry, and some update none.

The three control bits are loaded only through a separate write port. Arithmetic never changes them. Because the two writers touch disjoint bits, an operation and a control write in the same cycle both take effect. Byte mode works on the low eight bits only. The upper byte of the destination is carried through to the result unchanged.

Top module: `arith_flag_unit`

## Requirements
- R1: When rst_ni is asserted, flags_o clears to 0000h asynchronously.
- R2: The op_i encoding is 0 move, 1 exchange, 2 add, 3 subtract, 4 increment, 5 decrement, 6 negate and 7 no-op. The results are: move gives B. Exchange gives res_o=B and alt_o=A. Add gives A+B. Subtract gives A-B. Increment gives A+1. Decrement gives A-1. Negate gives 0-A. No-op gives A. alt_o is 0 for every operation except exchange. With wide_i=0, only bits 7:0 are computed and res_o[15:8]=A[15:8]. For a byte exchange, alt_o={B[15:8],A[7:0]}.
- R3: Carry (bit 0) is set on a carry out of the top bit of the selected width for add, and on a borrow into that bit for subtract. It is cleared otherwise.
- R4: Parity (bit 2) is 1 exactly when res_o[7:0] holds an even number of ones, at either width.
- R5: Auxiliary carry (bit 4) is set on a carry out of bit 3 for addition, and on a borrow into bit 3 for subtraction-type operations.
- R6: Zero (bit 6) is set exactly when the result at the selected width is all zeros. Sign (bit 7) equals the top bit of the result at that width.
- R7: Overflow (bit 11) is set on signed overflow. For addition this means equal operand signs and a result sign that differs from them. For subtraction it means different operand signs and a result sign that differs from the minuend.
- R8: Move, exchange and no-op leave all status bits unchanged.
- R9: Increment and decrement update every status bit except carry, which keeps its value.
- R10: Negate sets carry unless the result is zero. It sets overflow only for the operand 8000h (word) or 80h (byte).
- R11: The status bits change only on a rising clock edge where op_valid_i=1, and the new value appears on flags_o after that edge.
- R12: When ctl_we_i=1, ctl_i[2:0] loads bits 10:8 (trap, interrupt enable, direction) at the edge. Arithmetic never alters these bits. Bits 1, 3, 5 and 15:12 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | Operation strobe; enables the status update |
| op_i | input | 3 | Operation code |
| wide_i | input | 1 | 1 = 16-bit, 0 = 8-bit |
| a_i | input | 16 | Destination operand |
| b_i | input | 16 | Source operand |
| res_o | output | 16 | Operation result |
| alt_o | output | 16 | Second result of exchange (old A) |
| ctl_we_i | input | 1 | Control-bit write enable |
| ctl_i | input | 3 | Control bits for positions 10:8 |
| flags_o | output | 16 | Status register |

## Verification
A wrong internal state, such as a bad carry chain, a wrong width mux or a wrong update mask, shows up at res_o in the same cycle as the operands. It shows up at flags_o one edge after the strobe. The bench compares both ports against a width-aware model after every operation, so a fault appears within a single operation. Retained bits such as carry after increment or decrement, and the control bits, are only corrupted when they are written wrongly. Those faults appear on the next check of flags_o, because every check compares the whole register.

// File: rtl/afu_pkg.sv
package afu_pkg;
  typedef enum logic [2:0] {
    OP_MOV  = 3'd0,
    OP_XCHG = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_INC  = 3'd4,
    OP_DEC  = 3'd5,
    OP_NEG  = 3'd6,
    OP_NOP  = 3'd7
  } afu_op_e;

  localparam int FLAG_W = 16;
  localparam int CF_B = 0;
  localparam int PF_B = 2;
  localparam int AF_B = 4;
  localparam int ZF_B = 6;
  localparam int SF_B = 7;
  localparam int CTL_LO = 8;
  localparam int CTL_W = 3;
  localparam int OF_B = 11;

  typedef struct packed {
    logic cf;
    logic pf;
    logic af;
    logic zf;
    logic sf;
    logic of;
  } stat_t;
endpackage

// File: rtl/afu_datapath.sv
module afu_datapath
  import afu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int NIB_W  = 4
) (
  input  afu_op_e             op_i,
  input  logic                wide_i,
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   b_i,
  output logic [DATA_W-1:0]   res_o,
  output logic [DATA_W-1:0]   alt_o,
  output stat_t               stat_o
);
  localparam int HI_W = DATA_W - BYTE_W;

  logic              sub_mode;
  logic [DATA_W-1:0] opx, opy, opy_eff, ar;
  logic [DATA_W:0]   sum_w;
  logic [BYTE_W:0]   sum_b;
  logic [NIB_W:0]    sum_n;
  logic              cout, sx, sy, sr;

  always_comb begin
    opx      = a_i;
    opy      = b_i;
    sub_mode = 1'b0;
    unique case (op_i)
      OP_SUB: sub_mode = 1'b1;
      OP_INC: opy = DATA_W'(1);
      OP_DEC: begin opy = DATA_W'(1); sub_mode = 1'b1; end
      OP_NEG: begin opx = '0; opy = a_i; sub_mode = 1'b1; end
      default: ;
    endcase
  end

  // subtraction as x + ~y + 1; borrow is the inverted carry
  assign opy_eff = sub_mode ? ~opy : opy;
  assign sum_w = {1'b0, opx} + {1'b0, opy_eff} + {{DATA_W{1'b0}}, sub_mode};
  assign sum_b = {1'b0, opx[BYTE_W-1:0]} + {1'b0, opy_eff[BYTE_W-1:0]}
               + {{BYTE_W{1'b0}}, sub_mode};
  assign sum_n = {1'b0, opx[NIB_W-1:0]} + {1'b0, opy_eff[NIB_W-1:0]}
               + {{NIB_W{1'b0}}, sub_mode};

  assign ar   = wide_i ? sum_w[DATA_W-1:0] : {a_i[DATA_W-1:BYTE_W], sum_b[BYTE_W-1:0]};
  assign cout = wide_i ? sum_w[DATA_W] : sum_b[BYTE_W];
  assign sx   = wide_i ? opx[DATA_W-1] : opx[BYTE_W-1];
  assign sy   = wide_i ? opy_eff[DATA_W-1] : opy_eff[BYTE_W-1];
  assign sr   = wide_i ? ar[DATA_W-1] : ar[BYTE_W-1];

  assign stat_o.cf = cout ^ sub_mode;
  assign stat_o.af = sum_n[NIB_W] ^ sub_mode;
  assign stat_o.pf = ~^ar[BYTE_W-1:0];
  assign stat_o.zf = wide_i ? (ar == '0) : (ar[BYTE_W-1:0] == '0);
  assign stat_o.sf = sr;
  assign stat_o.of = (sx == sy) && (sr != sx);

  always_comb begin
    alt_o = '0;
    unique case (op_i)
      OP_MOV: res_o = wide_i ? b_i : {a_i[DATA_W-1:BYTE_W], b_i[BYTE_W-1:0]};
      OP_XCHG: begin
        res_o = wide_i ? b_i : {a_i[DATA_W-1:BYTE_W], b_i[BYTE_W-1:0]};
        alt_o = wide_i ? a_i : {b_i[DATA_W-1:BYTE_W], a_i[BYTE_W-1:0]};
      end
      OP_NOP:  res_o = a_i;
      default: res_o = ar;
    endcase
  end

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = '0;
endmodule

// File: rtl/afu_flag_update.sv
module afu_flag_update
  import afu_pkg::*;
(
  input  afu_op_e           op_i,
  input  logic              valid_i,
  input  stat_t             stat_i,
  input  logic              ctl_we_i,
  input  logic [CTL_W-1:0]  ctl_i,
  input  logic [FLAG_W-1:0] flags_q_i,
  output logic [FLAG_W-1:0] flags_d_o
);
  localparam logic [FLAG_W-1:0] LIVE_MASK =
    FLAG_W'((1 << CF_B) | (1 << PF_B) | (1 << AF_B) | (1 << ZF_B) | (1 << SF_B) |
            (1 << OF_B) | (((1 << CTL_W) - 1) << CTL_LO));

  logic wr_all, wr_nocf;

  always_comb begin
    wr_all  = 1'b0;
    wr_nocf = 1'b0;
    if (valid_i) begin
      unique case (op_i)
        OP_ADD, OP_SUB, OP_NEG: wr_all  = 1'b1;
        OP_INC, OP_DEC:         wr_nocf = 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    flags_d_o = flags_q_i;
    if (wr_all) flags_d_o[CF_B] = stat_i.cf;
    if (wr_all || wr_nocf) begin
      flags_d_o[PF_B] = stat_i.pf;
      flags_d_o[AF_B] = stat_i.af;
      flags_d_o[ZF_B] = stat_i.zf;
      flags_d_o[SF_B] = stat_i.sf;
      flags_d_o[OF_B] = stat_i.of;
    end
    if (ctl_we_i) flags_d_o[CTL_LO +: CTL_W] = ctl_i;
    flags_d_o = flags_d_o & LIVE_MASK;
  end
endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
  import afu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [2:0]        op_i,
  input  logic              wide_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o,
  output logic [DATA_W-1:0] alt_o,
  input  logic              ctl_we_i,
  input  logic [2:0]        ctl_i,
  output logic [15:0]       flags_o
);
  afu_op_e           op;
  stat_t             stat;
  logic [FLAG_W-1:0] flags_q, flags_d;

  assign op = afu_op_e'(op_i);

  afu_datapath #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_dp (
    .op_i(op), .wide_i(wide_i), .a_i(a_i), .b_i(b_i),
    .res_o(res_o), .alt_o(alt_o), .stat_o(stat)
  );

  afu_flag_update u_upd (
    .op_i(op), .valid_i(op_valid_i), .stat_i(stat),
    .ctl_we_i(ctl_we_i), .ctl_i(ctl_i),
    .flags_q_i(flags_q), .flags_d_o(flags_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  logic [5:0] stat_bits;
  assign stat_bits = {flags_q[OF_B], flags_q[SF_B], flags_q[ZF_B],
                      flags_q[AF_B], flags_q[PF_B], flags_q[CF_B]};

  assert_rsvd_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_q & 16'hF02A) == '0);
  assert_ctl_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_we_i |=> $stable(flags_q[CTL_LO +: CTL_W]));
  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> $stable(stat_bits));
  assert_move_no_flags_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && (op_i == 3'd0 || op_i == 3'd1 || op_i == 3'd7) |=> $stable(stat_bits));
  assert_keep_carry_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && (op_i == 3'd4 || op_i == 3'd5) |=> $stable(flags_q[CF_B]));
  assert_zero_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && (op_i == 3'd2 || op_i == 3'd3) |=>
      flags_q[ZF_B] == $past(wide_i ? (res_o == '0) : (res_o[BYTE_W-1:0] == '0)));
  assert_neg_carry_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && op_i == 3'd6 |=>
      flags_q[CF_B] == $past(wide_i ? (a_i != '0) : (a_i[BYTE_W-1:0] != '0)));
endmodule

// File: tb/arith_flag_unit_bench.sv
module arith_flag_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, op_valid, wide, ctl_we;
  logic [2:0]  op, ctl;
  logic [15:0] a, b, res, alt, flags;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] exp_flags;

  arith_flag_unit u_arith_flag_unit (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_i(op), .wide_i(wide),
    .a_i(a), .b_i(b), .res_o(res), .alt_o(alt), .ctl_we_i(ctl_we), .ctl_i(ctl),
    .flags_o(flags)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // reference model computed from the requirements
  task automatic model(input logic [2:0] o, input logic w, input logic [15:0] x,
                       input logic [15:0] y, input logic [15:0] fin,
                       output logic [15:0] r, output logic [15:0] r2,
                       output logic [15:0] fout);
    int m, top, xa, ya, rr;
    bit cf, af, of, upd, keepc, sxa, sya, sr, zf, pf;
    m = w ? 32'hFFFF : 32'hFF;
    top = w ? 15 : 7;
    xa = int'(x) & m;
    ya = int'(y) & m;
    r2 = 16'h0;
    upd = 1; keepc = 0; cf = 0; af = 0; of = 0; rr = 0;
    case (o)
      3'd0, 3'd1: begin
        rr = ya; upd = 0;
        if (o == 3'd1) r2 = w ? x : {y[15:8], x[7:0]};
      end
      3'd7: begin rr = xa; upd = 0; end
      3'd2, 3'd4: begin
        if (o == 3'd4) begin ya = 1; keepc = 1; end
        rr = xa + ya;
        cf = rr > m;
        af = ((xa & 15) + (ya & 15)) > 15;
        sxa = xa[top]; sya = ya[top]; sr = rr[top];
        of = (sxa == sya) && (sr != sxa);
      end
      default: begin
        if (o == 3'd5) begin ya = 1; keepc = 1; end
        if (o == 3'd6) begin ya = xa; xa = 0; end
        rr = xa - ya;
        cf = xa < ya;
        af = (xa & 15) < (ya & 15);
        sxa = xa[top]; sya = ya[top]; sr = rr[top];
        of = (sxa != sya) && (sr != sxa);
      end
    endcase
    rr = rr & m;
    r = w ? rr[15:0] : {x[15:8], rr[7:0]};
    zf = (rr == 0);
    pf = ~^rr[7:0];
    fout = fin;
    if (upd) begin
      if (!keepc) fout[0] = cf;
      fout[2] = pf; fout[4] = af; fout[6] = zf; fout[7] = rr[top]; fout[11] = of;
    end
  endtask

  task automatic step(input logic v, input logic [2:0] o, input logic w,
                      input logic [15:0] x, input logic [15:0] y,
                      input logic cw, input logic [2:0] cv, input string req);
    logic [15:0] er, er2, ef;
    @(negedge clk);
    op_valid = v; op = o; wide = w; a = x; b = y; ctl_we = cw; ctl = cv;
    #1;
    model(o, w, x, y, exp_flags, er, er2, ef);
    chk({req, " R2 res"}, res, er);
    chk("R2 alt", alt, er2);
    if (v) exp_flags = ef;
    if (cw) exp_flags[10:8] = cv;
    @(negedge clk);
    op_valid = 0; ctl_we = 0;
    chk({req, " R11 flags"}, flags, exp_flags);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    end
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h1badcafe;
    void'($urandom(seed));
    rst_n = 0; op_valid = 0; op = 0; wide = 1; a = 0; b = 0; ctl_we = 0; ctl = 0;
    exp_flags = 16'h0;
    #(CLK_PERIOD * 2 + 3);
    chk("R1 reset", flags, 16'h0000);
    @(negedge clk);
    rst_n = 1;

    // directed corner cases
    step(1, 3'd2, 1, 16'hFFFF, 16'hFFFF, 0, 3'd0, "R3 R7 add FFFF+FFFF");
    chk("R3 R4 R6 R7 flags", flags, 16'h0091); // CF=1 AF=1 SF=1 PF=0 ZF=0 OF=0
    step(1, 3'd2, 0, 16'h1280, 16'h3480, 0, 3'd0, "R7 byte 80+80");
    chk("R7 R6 byte flags", flags, 16'h0845); // CF ZF PF OF
    chk("R2 byte upper pass", res, 16'h1200);
    step(1, 3'd3, 1, 16'h8000, 16'h0001, 0, 3'd0, "R7 sub 8000-1");
    chk("R5 R7 sub flags", flags, 16'h0814);
    step(1, 3'd4, 0, 16'h00FF, 16'h0000, 0, 3'd0, "R9 inc FF keeps CF");
    chk("R9 carry kept", flags, 16'h0054);
    step(1, 3'd6, 1, 16'h8000, 16'h0000, 0, 3'd0, "R10 neg 8000");
    chk("R10 neg 8000 flags", flags, 16'h0885);
    step(1, 3'd6, 0, 16'hAB00, 16'h0000, 0, 3'd0, "R10 neg zero byte");
    chk("R10 neg 0 CF clear", flags, 16'h0044);
    step(0, 3'd2, 1, 16'hFFFF, 16'h0001, 1, 3'd5, "R11 R12 no strobe ctl write");
    chk("R12 ctl loaded", flags, 16'h0544);
    step(1, 3'd1, 1, 16'h1234, 16'h5678, 0, 3'd0, "R8 xchg");
    chk("R8 xchg alt", alt, 16'h1234);
    step(1, 3'd2, 1, 16'h7FFF, 16'h0001, 1, 3'd2, "R12 add with ctl write");

    for (int i = 0; i < 3000; i++) begin
      logic [15:0] x, y;
      logic [2:0] o;
      x = 16'($urandom);
      y = 16'($urandom);
      if (($urandom % 8) == 0) y = x;
      if (($urandom % 8) == 0) x = 16'h8000 >> ($urandom % 9);
      o = 3'($urandom);
      step(($urandom % 6) != 0, o, 1'($urandom), x, y,
           ($urandom % 5) == 0, 3'($urandom), "R3 R4 R5 R6 R7 R8 R9 R10 R12 random");
    end

    rst_n = 0;
    #2;
    chk("R1 async reset", flags, 16'h0000);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    end
    $finish;
  end
endmodule